// File: doc/BRIEF.md
# Programmable Watchdog Timer with Selectable Time Base

This block watches for a stalled processor. Software programs one 7-bit control value. That value holds a 5-bit multiplier and a 2-bit resolution code. The time-out is the multiplier times the chosen base period.

All four base periods come from a single 16 Hz tick input, divided by 1, 4, 16 or 64. Every write to the control value restarts the count. When the count runs out, the block raises a sticky watchdog flag and an interrupt request, then stops counting until the next write.

Software clears the flag by reading the flag register. It releases the interrupt by writing zero, which also disarms the timer. While the timer is armed, the block also tells a neighbouring frequency-test output to stand aside, unless the square-wave output already owns the pin.

Top module: `wdog_timer`

## Requirements
- R1: After reset the control value is zero, the timer is disarmed, and both `wd_flag` and `wd_irq` are 0.
- R2: The control value uses bits [6:2] as multiplier M and bits [1:0] as resolution code r. Each code selects a base period of 4^r input ticks: 00→1, 01→4, 10→16, 11→64. `wd_flag` stays 0 through tick M·4^r−1 after the last write. It is 1 right after the clock edge that samples tick M·4^r.
- R3: Any write to the control value restarts the time-out from zero, even a write of the same value. A tick that arrives in the same cycle as a write is discarded.
- R4: On expiry both `wd_flag` and `wd_irq` become 1. The timer then halts: no further expiry happens until the next write.
- R5: `wd_irq` stays 1 until a write of zero. A nonzero write restarts the timer but leaves `wd_irq` at 1.
- R6: A pulse on `flag_rd` clears `wd_flag` and leaves `wd_irq` unchanged. An expiry in the same cycle as a `flag_rd` pulse wins, so the flag ends up 1.
- R7: A multiplier of zero disarms the timer for any resolution code. No expiry ever occurs while it is disarmed.
- R8: `ftest_block` is 1 exactly when the multiplier is nonzero, `ftest_req` is 1 and `sqw_en` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| tick_16hz | input | 1 | One-cycle pulse at the 16 Hz base rate |
| cfg_wr | input | 1 | Write strobe for the control value |
| cfg_wdata | input | 7 | Control value: multiplier [6:2], resolution [1:0] |
| flag_rd | input | 1 | Flag-register read strobe; clears the flag |
| ftest_req | input | 1 | Frequency-test output requested |
| sqw_en | input | 1 | Square-wave output enabled |
| wd_flag | output | 1 | Sticky watchdog expiry flag |
| wd_irq | output | 1 | Watchdog interrupt request |
| ftest_block | output | 1 | Frequency test suppressed by the watchdog |

## Verification
The bench sweeps every multiplier from 1 to 31 under every resolution code. It checks that the flag is still low one tick before the computed time-out and high on the tick itself. This separates a wrong prescale ratio, an off-by-one in either counter, and a swapped field.

Directed sequences cover the following cases:
- a restart written in the middle of a count, and a tick that coincides with a write;
- the halt after expiry;
- a nonzero write while the interrupt is pending;
- a flag read that lands on the expiry cycle;
- a zero multiplier with a nonzero resolution code.

The frequency-test arbitration is swept over all eight input combinations with the timer armed and disarmed.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int MULT_W   = 5;
    localparam int RES_W    = 2;
    localparam int DIV_STEP = 2;   // each resolution step divides by 2**DIV_STEP
endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
    parameter int RES_W = wdog_pkg::RES_W,
    parameter int STEP  = wdog_pkg::DIV_STEP
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic             tick,
    input  logic [RES_W-1:0] res,
    output logic             base_tick
);
    localparam int NRES  = 1 << RES_W;
    localparam int PRE_W = STEP * (NRES - 1);

    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_st_t;

    pre_st_t st_d, st_q;
    logic [PRE_W-1:0] lim_tab [NRES];
    logic [PRE_W-1:0] lim;

    for (genvar g = 0; g < NRES; g++) begin : g_lim
        assign lim_tab[g] = PRE_W'((1 << (STEP * g)) - 1);
    end

    assign lim = lim_tab[res];

    always_comb begin
        st_d      = st_q;
        base_tick = 1'b0;
        if (clear) begin
            st_d.cnt = '0;
        end else if (run && tick) begin
            if (st_q.cnt == lim) begin
                st_d.cnt  = '0;
                base_tick = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_PRE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (st_q.cnt <= lim)); // R2
endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
    parameter int MULT_W = wdog_pkg::MULT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              base_tick,
    input  logic [MULT_W-1:0] mult,
    output logic              active,
    output logic              expire
);
    typedef struct packed {
        logic [MULT_W-1:0] cnt;
        logic              done;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    assign active = (mult != '0) && !st_q.done;

    always_comb begin
        st_d   = st_q;
        expire = 1'b0;
        if (clear) begin
            st_d.cnt  = '0;
            st_d.done = 1'b0;
        end else if (active && base_tick) begin
            if (st_q.cnt == mult - 1'b1) begin
                expire    = 1'b1;
                st_d.cnt  = '0;
                st_d.done = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_CNT_BELOW_MULT: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (st_q.cnt < mult)); // R2
    AST_HALT_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.done && !clear) |=> st_q.done); // R4
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
    parameter int MULT_W   = wdog_pkg::MULT_W,
    parameter int RES_W    = wdog_pkg::RES_W,
    parameter int DIV_STEP = wdog_pkg::DIV_STEP
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_16hz,
    input  logic       cfg_wr,
    input  logic [6:0] cfg_wdata,
    input  logic       flag_rd,
    input  logic       ftest_req,
    input  logic       sqw_en,
    output logic       wd_flag,
    output logic       wd_irq,
    output logic       ftest_block
);
    localparam int CFG_W = MULT_W + RES_W;

    typedef struct packed {
        logic [CFG_W-1:0] cfg;
        logic             flag;
        logic             irq;
    } ctl_st_t;

    ctl_st_t           st_d, st_q;
    logic              armed;
    logic              active;
    logic              base_tick;
    logic              expire;
    logic [MULT_W-1:0] mult;
    logic [RES_W-1:0]  res;

    assign mult  = st_q.cfg[RES_W +: MULT_W];
    assign res   = st_q.cfg[RES_W-1:0];
    assign armed = (mult != '0);

    wdog_prescale #(.RES_W(RES_W), .STEP(DIV_STEP)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (cfg_wr),
        .run       (active),
        .tick      (tick_16hz),
        .res       (res),
        .base_tick (base_tick)
    );

    wdog_count #(.MULT_W(MULT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (cfg_wr),
        .base_tick (base_tick),
        .mult      (mult),
        .active    (active),
        .expire    (expire)
    );

    always_comb begin
        st_d = st_q;
        if (cfg_wr) begin
            st_d.cfg = cfg_wdata[CFG_W-1:0];
            if (cfg_wdata[CFG_W-1:0] == '0) st_d.irq = 1'b0;
        end
        if (expire) begin
            st_d.flag = 1'b1;
            st_d.irq  = 1'b1;
        end else if (flag_rd) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wd_flag     = st_q.flag;
    assign wd_irq      = st_q.irq;
    assign ftest_block = armed && ftest_req && !sqw_en;

    AST_FLAG_FROM_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wd_flag) |-> $past(expire)); // R4
    AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_irq && !(cfg_wr && cfg_wdata == 7'h00)) |=> wd_irq); // R5
    AST_ZERO_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_wdata == 7'h00) |=> !wd_irq); // R5
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_rd && !expire) |=> !wd_flag); // R6
    AST_DISARMED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |=> !$rose(wd_flag)); // R7
endmodule

// File: tb/wdog_timer_tb.sv
`timescale 1ns/1ps
module wdog_timer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_16hz = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [6:0] cfg_wdata = '0;
    logic       flag_rd = 1'b0;
    logic       ftest_req = 1'b0;
    logic       sqw_en = 1'b0;
    logic       wd_flag, wd_irq, ftest_block;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    wdog_timer u_dut (
        .clk(clk), .rst_n(rst_n), .tick_16hz(tick_16hz), .cfg_wr(cfg_wr),
        .cfg_wdata(cfg_wdata), .flag_rd(flag_rd), .ftest_req(ftest_req),
        .sqw_en(sqw_en), .wd_flag(wd_flag), .wd_irq(wd_irq),
        .ftest_block(ftest_block)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000 && !done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 190000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick_16hz = 1'b1; @(negedge clk);
            tick_16hz = 1'b0; @(negedge clk);
        end
    endtask

    task automatic wr(input logic [6:0] v);
        cfg_wr = 1'b1; cfg_wdata = v; @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd_flag();
        flag_rd = 1'b1; @(negedge clk);
        flag_rd = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        ftest_req = 1'b1;
        #0;
        chk("R1 flag", wd_flag, 0);
        chk("R1 irq", wd_irq, 0);
        chk("R1 disarmed ftest_block", ftest_block, 0);
        ftest_req = 1'b0;

        // R2 exhaustive sweep of multiplier and resolution
        for (int r = 0; r < 4; r++) begin
            for (int m = 1; m < 32; m++) begin
                int n;
                n = m << (2 * r);
                wr({m[4:0], r[1:0]});
                ticks(n - 1);
                chk($sformatf("R2 early m=%0d r=%0d flag", m, r), wd_flag, 0);
                chk($sformatf("R2 early m=%0d r=%0d irq", m, r), wd_irq, 0);
                ticks(1);
                chk($sformatf("R2/R4 expiry m=%0d r=%0d flag", m, r), wd_flag, 1);
                chk($sformatf("R4 expiry m=%0d r=%0d irq", m, r), wd_irq, 1);
                rd_flag();
                wr(7'h00);
            end
        end

        // R3 restart mid count (value 0x0E: M=3, r=2 -> 48 ticks)
        wr(7'h0E);
        ticks(30);
        wr(7'h0E);
        ticks(47);
        chk("R3 restart not yet expired", wd_flag, 0);
        ticks(1);
        chk("R3 restart expiry", wd_flag, 1);
        rd_flag(); wr(7'h00);

        // R3 tick coinciding with write is discarded
        cfg_wr = 1'b1; cfg_wdata = 7'h0E; tick_16hz = 1'b1; @(negedge clk);
        cfg_wr = 1'b0; tick_16hz = 1'b0; @(negedge clk);
        ticks(47);
        chk("R3 coincident tick ignored", wd_flag, 0);
        ticks(1);
        chk("R3 coincident expiry", wd_flag, 1);

        // R4 halt after expiry; R6 read keeps irq
        rd_flag();
        chk("R6 read clears flag", wd_flag, 0);
        chk("R6 read keeps irq", wd_irq, 1);
        ticks(200);
        chk("R4 halted no re-expiry", wd_flag, 0);

        // R5 nonzero write keeps irq and restarts (0x04: M=1, r=0)
        wr(7'h04);
        chk("R5 nonzero write keeps irq", wd_irq, 1);
        chk("R5 nonzero write no flag yet", wd_flag, 0);
        // R6 expiry and read in same cycle: expiry wins
        tick_16hz = 1'b1; flag_rd = 1'b1; @(negedge clk);
        tick_16hz = 1'b0; flag_rd = 1'b0;
        chk("R6 expiry beats read", wd_flag, 1);
        wr(7'h00);
        chk("R5 zero write releases irq", wd_irq, 0);
        chk("R5 zero write leaves flag", wd_flag, 1);
        rd_flag();

        // R7 zero multiplier with nonzero resolution
        wr(7'h03);
        ticks(300);
        chk("R7 zero multiplier flag", wd_flag, 0);
        chk("R7 zero multiplier irq", wd_irq, 0);

        // R8 frequency-test suppression
        for (int a = 0; a < 2; a++) begin
            wr(a ? 7'h7C : 7'h00);
            for (int k = 0; k < 4; k++) begin
                ftest_req = k[0]; sqw_en = k[1];
                #1;
                chk($sformatf("R8 armed=%0d req=%0d sqw=%0d", a, k[0], k[1]),
                    ftest_block, (a == 1 && k[0] && !k[1]) ? 1 : 0);
                @(negedge clk);
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule